// File: doc/BRIEF.md
# Nibble-pair DRAM access sequencer

This block is the timing engine for a byte-wide memory built from a DRAM array that is only four bits wide. A free-running base clock (nominally 16 MHz) is divided into 500 ns slots of eight phases. Every slot carries exactly one DRAM access: the row strobe falls once, and while it stays low the column strobe pulses twice. The two column addresses differ only in their lowest bit, so the two half-bytes of one byte are fetched back to back and merged into a single 8-bit result.

The same slot grid produces the CPU clock. At each falling edge of that clock the block captures the CPU address, the read/write line, a "target is ROM" flag and the write data. A RAM access stretches the CPU clock to a full slot low followed by a full slot high (1 MHz). A ROM access runs it at 2 MHz, a quarter-slot... more precisely half a slot low and half a slot high. During the low slot of a RAM write, write enable is pulled low ahead of the first column strobe and the two half-bytes are presented in turn. During the low slot of a RAM read, the two captured half-bytes are assembled and announced with a one-cycle valid pulse.

Top module: `nibble_pair_dram_seq`

## Requirements
- R1: While reset is asserted and until the first phase advance after its synchronous release, the row strobe, column strobe and write enable are high, the CPU clock is low and the read-valid flag is low.
- R2: In every slot the row strobe is high for phase 0 only and low for phases 1 to 7, i.e. one high cycle followed by seven low cycles.
- R3: The column strobe is low in phases 3, 4, 6 and 7 and high otherwise: two pulses of two cycles each, separated by one high cycle, both inside the row-strobe low interval.
- R4: The DRAM address bus carries the row, byte-address bits [2N-2:N-1], in phases 0 and 1, the even column {byte-address bits [N-2:0], 0} in phases 2 to 4 and the odd column {byte-address bits [N-2:0], 1} in phases 5 to 7 (N is the DRAM address width), so every strobe falls on an address that has been stable for one cycle.
- R5: In the low slot of a RAM read, the half-byte present at the end of phase 4 becomes result bits 3:0 and the half-byte present at the end of phase 7 becomes bits 7:4; the byte appears with a one-cycle valid pulse in phase 0 of the following slot.
- R6: For a RAM access the CPU clock falls at a slot start, stays low for 8 base cycles and then high for 8 base cycles.
- R7: For a ROM access the CPU clock falls at a slot start, stays low for 4 base cycles and then high for 4 base cycles.
- R8: Address, read/write, ROM flag and write data are captured only on the falling edge of the CPU clock; changes to them at any other time have no effect on the access in progress.
- R9: In the low slot of a RAM write, write enable is low in phases 2 to 7, so it falls before the first column strobe; the write-data half-byte is bits 3:0 at the even-column strobe and bits 7:4 at the odd-column strobe; no read-valid pulse follows.
- R10: ROM accesses and the high slot of a RAM access produce neither a write-enable pulse nor a read-valid pulse.
- R11: After reset the first CPU clock cycle is an idle ROM-length cycle (4 low, 4 high) that neither writes nor reports read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, one cycle per phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr_i | input | 2*DRAM_AW-1 | CPU byte address |
| cpu_rnw_i | input | 1 | CPU read (1) or write (0) |
| cpu_rom_i | input | 1 | Access targets ROM (1) or RAM (0) |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_clk_o | output | 1 | Generated CPU clock |
| dram_addr_o | output | DRAM_AW | Multiplexed DRAM row/column address |
| dram_ras_n_o | output | 1 | Row strobe, active low |
| dram_cas_n_o | output | 1 | Column strobe, active low |
| dram_we_n_o | output | 1 | Write enable, active low |
| dram_wdata_o | output | 4 | Half-byte to be written |
| dram_rdata_i | input | 4 | Half-byte read from the array |
| rdata_o | output | 8 | Assembled read byte |
| rdata_valid_o | output | 1 | One-cycle pulse marking a new read byte |

## Verification
The assertions watch the strobe shapes every cycle: the single-cycle row precharge, column pulses nested inside the row strobe and at least two cycles long, the address holding still across each strobe fall, write enable only in a low CPU phase and ahead of the column strobe, CPU clock edges landing on the right phase, and capture registers that move only at the CPU clock fall. What only the scenarios show is the data path end to end: that the row and both columns select the right half-bytes of the right byte, that they are merged in the right order, that written half-bytes leave in order, that inputs toggled mid-slot are ignored, and that the measured CPU clock lengths match the RAM or ROM target of each access.

// File: rtl/ndram_pkg.sv
package ndram_pkg;

  localparam int PHASE_W = 3;
  localparam int NIB_W   = 4;
  localparam int BYTE_W  = 2 * NIB_W;

  typedef logic [PHASE_W-1:0] phase_t;

  localparam phase_t PH_FIRST   = phase_t'(0);
  localparam phase_t PH_LAST    = phase_t'((1 << PHASE_W) - 1);
  localparam phase_t PH_HALF    = phase_t'(1 << (PHASE_W - 1));
  localparam phase_t PH_CAP_LO  = phase_t'(4);
  localparam phase_t PH_WE_OPEN = phase_t'(2);

  typedef enum logic [1:0] {
    SEL_ROW,
    SEL_COL_EVEN,
    SEL_COL_ODD
  } addr_sel_e;

  // row strobe low everywhere except the precharge phase
  function automatic logic row_strobe_on(input phase_t p);
    return p != PH_FIRST;
  endfunction

  // two column pulses: phases 3-4 and 6-7
  function automatic logic col_strobe_on(input phase_t p);
    return (p == phase_t'(3)) || (p == phase_t'(4)) ||
           (p == phase_t'(6)) || (p == phase_t'(7));
  endfunction

  function automatic addr_sel_e addr_sel(input phase_t p);
    if (p <= phase_t'(1))      return SEL_ROW;
    else if (p <= phase_t'(4)) return SEL_COL_EVEN;
    else                       return SEL_COL_ODD;
  endfunction

  function automatic logic we_window(input phase_t p);
    return p >= PH_WE_OPEN;
  endfunction

endpackage

// File: rtl/ndram_rst_sync.sv
module ndram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic stage_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      hold_q  <= stage_q;
    end
  end

  assign rst_s_n = hold_q;

endmodule

// File: rtl/ndram_phase_ctr.sv
module ndram_phase_ctr
  import ndram_pkg::*;
(
  input  logic   clk,
  input  logic   rst_s_n,
  output phase_t phase_q,
  output phase_t phase_d
);

  logic advance;

  always_comb begin
    advance = 1'b1;
    phase_d = phase_q;
    if (advance) phase_d = phase_q + phase_t'(1);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) phase_q <= PH_FIRST;
    else          phase_q <= phase_d;
  end

endmodule

// File: rtl/ndram_cpu_phase.sv
module ndram_cpu_phase
  import ndram_pkg::*;
#(
  parameter int BYTE_AW = 15
) (
  input  logic               clk,
  input  logic               rst_s_n,
  input  phase_t             phase_q,
  input  logic [BYTE_AW-1:0] cpu_addr_i,
  input  logic               cpu_rnw_i,
  input  logic               cpu_rom_i,
  input  logic [BYTE_W-1:0]  cpu_wdata_i,
  output logic               phi_q,
  output logic [BYTE_AW-1:0] addr_d,
  output logic [BYTE_W-1:0]  wdata_d,
  output logic               wr_slot_d,
  output logic               rd_slot_q
);

  logic               phi_d;
  logic               fall_ev;
  logic               rise_ev;
  logic [BYTE_AW-1:0] addr_q;
  logic [BYTE_W-1:0]  wdata_q;
  logic               rnw_q, rnw_d;
  logic               rom_q, rom_d;

  always_comb begin
    fall_ev = phi_q && (phase_q == PH_LAST);
    rise_ev = !phi_q && (((phase_q == PH_LAST) && !rom_q) ||
                         ((phase_q == PH_HALF - phase_t'(1)) && rom_q));
    phi_d   = phi_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    rnw_d   = rnw_q;
    rom_d   = rom_q;
    if (fall_ev) begin
      phi_d   = 1'b0;
      addr_d  = cpu_addr_i;
      wdata_d = cpu_wdata_i;
      rnw_d   = cpu_rnw_i;
      rom_d   = cpu_rom_i;
    end else if (rise_ev) begin
      phi_d   = 1'b1;
    end
    wr_slot_d = !phi_d && !rom_d && !rnw_d;
    rd_slot_q = !phi_q && !rom_q && rnw_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      phi_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rnw_q   <= 1'b1;
      rom_q   <= 1'b1;
    end else begin
      phi_q   <= phi_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      rnw_q   <= rnw_d;
      rom_q   <= rom_d;
    end
  end

  // R6: the CPU clock falls only at a slot start
  a_r6_fall_at_slot_start: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(phi_q) |-> (phase_q == PH_FIRST));

  // R6: a RAM low phase ends at a slot boundary
  a_r6_ram_rise_at_slot_start: assert property (@(posedge clk) disable iff (!rst_s_n)
    ($rose(phi_q) && !rom_q) |-> (phase_q == PH_FIRST));

  // R7: a ROM low phase ends mid-slot
  a_r7_rom_rise_mid_slot: assert property (@(posedge clk) disable iff (!rst_s_n)
    ($rose(phi_q) && rom_q) |-> (phase_q == PH_HALF));

  // R8: captured access fields move only with the CPU clock fall
  a_r8_capture_only_on_fall: assert property (@(posedge clk) disable iff (!rst_s_n)
    !$fell(phi_q) |-> ($stable(addr_q) && $stable(rnw_q) && $stable(rom_q)));

endmodule

// File: rtl/ndram_strobe_gen.sv
module ndram_strobe_gen
  import ndram_pkg::*;
#(
  parameter  int DRAM_AW = 8,
  localparam int BYTE_AW = 2 * DRAM_AW - 1
) (
  input  logic               clk,
  input  logic               rst_s_n,
  input  phase_t             phase_d,
  input  logic [BYTE_AW-1:0] addr_d,
  input  logic [BYTE_W-1:0]  wdata_d,
  input  logic               wr_slot_d,
  output logic               ras_n_q,
  output logic               cas_n_q,
  output logic               we_n_q,
  output logic [DRAM_AW-1:0] dram_addr_q,
  output logic [NIB_W-1:0]   dram_wdata_q
);

  logic               ras_n_d, cas_n_d, we_n_d;
  logic [DRAM_AW-1:0] dram_addr_d;
  logic [NIB_W-1:0]   dram_wdata_d;
  logic [DRAM_AW-1:0] row_addr;
  logic [DRAM_AW-2:0] col_base;
  addr_sel_e          sel;

  always_comb begin
    row_addr     = addr_d[BYTE_AW-1 -: DRAM_AW];
    col_base     = addr_d[DRAM_AW-2:0];
    sel          = addr_sel(phase_d);
    ras_n_d      = !row_strobe_on(phase_d);
    cas_n_d      = !col_strobe_on(phase_d);
    we_n_d       = !(wr_slot_d && we_window(phase_d));
    dram_wdata_d = wdata_d[NIB_W-1:0];
    unique case (sel)
      SEL_ROW:      dram_addr_d = row_addr;
      SEL_COL_EVEN: dram_addr_d = {col_base, 1'b0};
      default: begin
        dram_addr_d  = {col_base, 1'b1};
        dram_wdata_d = wdata_d[BYTE_W-1:NIB_W];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ras_n_q      <= 1'b1;
      cas_n_q      <= 1'b1;
      we_n_q       <= 1'b1;
      dram_addr_q  <= '0;
      dram_wdata_q <= '0;
    end else begin
      ras_n_q      <= ras_n_d;
      cas_n_q      <= cas_n_d;
      we_n_q       <= we_n_d;
      dram_addr_q  <= dram_addr_d;
      dram_wdata_q <= dram_wdata_d;
    end
  end

  // R2: precharge lasts exactly one cycle
  a_r2_precharge_one_cycle: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(ras_n_q) |=> $fell(ras_n_q));

  // R3: column strobe only inside the row strobe
  a_r3_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_s_n)
    !cas_n_q |-> !ras_n_q);

  // R3: each column pulse is at least two cycles
  a_r3_cas_two_cycles: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(cas_n_q) |=> !cas_n_q);

  // R4: address settled across the row strobe fall
  a_r4_addr_stable_at_ras: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(ras_n_q) |-> $stable(dram_addr_q));

  // R4: address settled across each column strobe fall
  a_r4_addr_stable_at_cas: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(cas_n_q) |-> $stable(dram_addr_q));

  // R9: write enable leads the column strobe
  a_r9_we_before_cas: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(we_n_q) |-> cas_n_q);

endmodule

// File: rtl/ndram_nibble_cap.sv
module ndram_nibble_cap
  import ndram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_s_n,
  input  phase_t            phase_q,
  input  logic              rd_slot_q,
  input  logic [NIB_W-1:0]  dram_rdata_i,
  output logic [BYTE_W-1:0] rdata_q,
  output logic              rvalid_q
);

  logic [NIB_W-1:0]  lo_q, lo_d;
  logic [BYTE_W-1:0] rdata_d;
  logic              rvalid_d;
  logic              lo_en, hi_en;

  always_comb begin
    lo_en    = rd_slot_q && (phase_q == PH_CAP_LO);
    hi_en    = rd_slot_q && (phase_q == PH_LAST);
    lo_d     = lo_q;
    rdata_d  = rdata_q;
    rvalid_d = 1'b0;
    if (lo_en) lo_d = dram_rdata_i;
    if (hi_en) begin
      rdata_d  = {dram_rdata_i, lo_q};
      rvalid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      lo_q     <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      lo_q     <= lo_d;
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
    end
  end

  // R5: valid is a single-cycle pulse
  a_r5_valid_single_cycle: assert property (@(posedge clk) disable iff (!rst_s_n)
    rvalid_q |=> !rvalid_q);

  // R5: valid lands in the first phase of the next slot
  a_r5_valid_at_slot_start: assert property (@(posedge clk) disable iff (!rst_s_n)
    rvalid_q |-> (phase_q == PH_FIRST));

endmodule

// File: rtl/nibble_pair_dram_seq.sv
module nibble_pair_dram_seq
  import ndram_pkg::*;
#(
  parameter  int DRAM_AW = 8,
  localparam int BYTE_AW = 2 * DRAM_AW - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BYTE_AW-1:0] cpu_addr_i,
  input  logic               cpu_rnw_i,
  input  logic               cpu_rom_i,
  input  logic [7:0]         cpu_wdata_i,
  output logic               cpu_clk_o,
  output logic [DRAM_AW-1:0] dram_addr_o,
  output logic               dram_ras_n_o,
  output logic               dram_cas_n_o,
  output logic               dram_we_n_o,
  output logic [3:0]         dram_wdata_o,
  input  logic [3:0]         dram_rdata_i,
  output logic [7:0]         rdata_o,
  output logic               rdata_valid_o
);

  logic               rst_s_n;
  phase_t             phase_q, phase_d;
  logic [BYTE_AW-1:0] addr_d;
  logic [BYTE_W-1:0]  wdata_d;
  logic               wr_slot_d;
  logic               rd_slot_q;

  ndram_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  ndram_phase_ctr u_phase (
    .clk     (clk),
    .rst_s_n (rst_s_n),
    .phase_q (phase_q),
    .phase_d (phase_d)
  );

  ndram_cpu_phase #(.BYTE_AW(BYTE_AW)) u_cpu (
    .clk         (clk),
    .rst_s_n     (rst_s_n),
    .phase_q     (phase_q),
    .cpu_addr_i  (cpu_addr_i),
    .cpu_rnw_i   (cpu_rnw_i),
    .cpu_rom_i   (cpu_rom_i),
    .cpu_wdata_i (cpu_wdata_i),
    .phi_q       (cpu_clk_o),
    .addr_d      (addr_d),
    .wdata_d     (wdata_d),
    .wr_slot_d   (wr_slot_d),
    .rd_slot_q   (rd_slot_q)
  );

  ndram_strobe_gen #(.DRAM_AW(DRAM_AW)) u_strobe (
    .clk          (clk),
    .rst_s_n      (rst_s_n),
    .phase_d      (phase_d),
    .addr_d       (addr_d),
    .wdata_d      (wdata_d),
    .wr_slot_d    (wr_slot_d),
    .ras_n_q      (dram_ras_n_o),
    .cas_n_q      (dram_cas_n_o),
    .we_n_q       (dram_we_n_o),
    .dram_addr_q  (dram_addr_o),
    .dram_wdata_q (dram_wdata_o)
  );

  ndram_nibble_cap u_cap (
    .clk          (clk),
    .rst_s_n      (rst_s_n),
    .phase_q      (phase_q),
    .rd_slot_q    (rd_slot_q),
    .dram_rdata_i (dram_rdata_i),
    .rdata_q      (rdata_o),
    .rvalid_q     (rdata_valid_o)
  );

  // R9: write enable only while the CPU clock is low
  a_r9_we_in_low_phase: assert property (@(posedge clk) disable iff (!rst_s_n)
    !dram_we_n_o |-> !cpu_clk_o);

  // R10: read data is reported in the high phase following a RAM read
  a_r10_valid_in_high_phase: assert property (@(posedge clk) disable iff (!rst_s_n)
    rdata_valid_o |-> cpu_clk_o);

endmodule

// File: tb/nibble_pair_dram_seq_test.sv
module nibble_pair_dram_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] cpu_addr = '0;
  logic        cpu_rnw = 1'b1;
  logic        cpu_rom = 1'b1;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_clk_o;
  logic [7:0]  dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n;
  logic [3:0]  dram_wdata;
  logic [3:0]  dram_rdata = '0;
  logic [7:0]  rdata;
  logic        rdata_valid;

  always #2 clk = ~clk;

  nibble_pair_dram_seq uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_addr_i    (cpu_addr),
    .cpu_rnw_i     (cpu_rnw),
    .cpu_rom_i     (cpu_rom),
    .cpu_wdata_i   (cpu_wdata),
    .cpu_clk_o     (cpu_clk_o),
    .dram_addr_o   (dram_addr),
    .dram_ras_n_o  (dram_ras_n),
    .dram_cas_n_o  (dram_cas_n),
    .dram_we_n_o   (dram_we_n),
    .dram_wdata_o  (dram_wdata),
    .dram_rdata_i  (dram_rdata),
    .rdata_o       (rdata),
    .rdata_valid_o (rdata_valid)
  );

  typedef struct {
    bit          wr;
    logic [14:0] addr;
    logic [7:0]  data;
  } item_t;

  item_t exp_q[$];
  int    len_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    mon_on = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] nib_of(input logic [7:0] row, input logic [7:0] col);
    return row[3:0] ^ row[7:4] ^ col[3:0] ^ {col[6:4], col[7]} ^ 4'h5;
  endfunction

  function automatic bit cas_exp(input int k);
    return !(k == 3 || k == 4 || k == 6 || k == 7);
  endfunction

  // driver: one CPU access per CPU clock fall
  task automatic cpu_access(input logic [14:0] a, input bit rnw, input bit rom,
                            input logic [7:0] wd, input bit scramble);
    item_t it;
    @(posedge cpu_clk_o);
    @(posedge clk);
    @(negedge clk);
    cpu_addr  = a;
    cpu_rnw   = rnw;
    cpu_rom   = rom;
    cpu_wdata = wd;
    if (!rom) begin
      it.wr   = !rnw;
      it.addr = a;
      it.data = rnw ? {nib_of(a[14:7], {a[6:0], 1'b1}), nib_of(a[14:7], {a[6:0], 1'b0})} : wd;
      exp_q.push_back(it);
    end
    len_q.push_back(rom ? 4 : 8);
    @(negedge cpu_clk_o);
    if (scramble) begin
      repeat (2) @(negedge clk);
      cpu_addr  = ~a;
      cpu_rnw   = ~rnw;
      cpu_rom   = ~rom;
      cpu_wdata = ~wd;
    end
  endtask

  // monitor state
  logic [7:0] row_m, col_m, col_lo;
  logic [3:0] wlo;
  bit         prev_ras = 1'b1, prev_cas = 1'b1, prev_phi = 1'b0;
  bit         bad;
  bit         wn = 1'b0;
  bit         have_len = 1'b0;
  bit         first_hi = 1'b1;
  int         k = 0;
  int         lo_cnt = 0, hi_cnt = 0, exp_len = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      item_t it;
      // strobe shape, R2 and R3
      if (!dram_ras_n && prev_ras) begin
        row_m = dram_addr;
        k = 1;
        bad = !dram_cas_n;
      end else if (!dram_ras_n) begin
        k++;
        if (dram_cas_n != cas_exp(k)) bad = 1'b1;
      end else if (!prev_ras) begin
        chk(k == 7, "R2 row strobe low cycles", k, 7);
        chk(!bad, "R3 column strobe pattern", int'(bad), 0);
      end
      // column fall: latch column, capture writes (R4, R9)
      if (!dram_cas_n && prev_cas) begin
        col_m = dram_addr;
        if (!dram_we_n) begin
          if (!wn) begin
            wlo = dram_wdata;
            col_lo = dram_addr;
            wn = 1'b1;
          end else begin
            wn = 1'b0;
            if (exp_q.size() == 0) chk(0, "R10 unexpected write", 1, 0);
            else begin
              it = exp_q.pop_front();
              chk(it.wr, "R9 write in place of read", 0, 1);
              chk(row_m == it.addr[14:7], "R4 write row", row_m, it.addr[14:7]);
              chk(col_lo == {it.addr[6:0], 1'b0}, "R4 write even column", col_lo, {it.addr[6:0], 1'b0});
              chk(dram_addr == {it.addr[6:0], 1'b1}, "R4 write odd column", dram_addr, {it.addr[6:0], 1'b1});
              chk({dram_wdata, wlo} == it.data, "R9 write data", {dram_wdata, wlo}, it.data);
            end
          end
        end
      end
      dram_rdata = dram_cas_n ? 4'h0 : nib_of(row_m, col_m);
      // read results, R5
      if (rdata_valid) begin
        if (exp_q.size() == 0) chk(0, "R10 unexpected read valid", 1, 0);
        else begin
          it = exp_q.pop_front();
          chk(!it.wr, "R9 read valid after write", 1, 0);
          chk(rdata == it.data, "R5 read byte", rdata, it.data);
        end
      end
      // CPU clock lengths, R6 R7 R11
      if (cpu_clk_o && !prev_phi) begin
        if (len_q.size() != 0) begin
          exp_len = len_q.pop_front();
          chk(lo_cnt == exp_len, exp_len == 8 ? "R6 RAM low length" : "R7 ROM low length", lo_cnt, exp_len);
          have_len = 1'b1;
        end else have_len = 1'b0;
        hi_cnt = 0;
      end
      if (!cpu_clk_o && prev_phi) begin
        if (first_hi) chk(hi_cnt == 4, "R11 first high length", hi_cnt, 4);
        else if (have_len)
          chk(hi_cnt == exp_len, exp_len == 8 ? "R6 RAM high length" : "R7 ROM high length", hi_cnt, exp_len);
        first_hi = 1'b0;
        lo_cnt = 0;
      end
      if (cpu_clk_o) hi_cnt++;
      else lo_cnt++;
      prev_ras = dram_ras_n;
      prev_cas = dram_cas_n;
      prev_phi = cpu_clk_o;
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R5 watchdog: actual %0d cycles expected completion", 100000);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes high in reset",
        {dram_ras_n, dram_cas_n, dram_we_n}, 7);
    chk(!cpu_clk_o, "R1 CPU clock low in reset", cpu_clk_o, 0);
    chk(!rdata_valid, "R1 no valid in reset", rdata_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && !cpu_clk_o, "R1 held through sync release",
        {dram_ras_n, dram_cas_n, dram_we_n, cpu_clk_o}, 14);
    mon_on = 1'b1;
    // R11 first idle cycle measured by the monitor; then R5/R6 reads
    cpu_access(15'h0000, 1'b1, 1'b0, 8'h00, 1'b0);
    cpu_access(15'h7FFF, 1'b1, 1'b0, 8'h00, 1'b0);
    cpu_access(15'h2A55, 1'b1, 1'b0, 8'h00, 1'b1);   // R8 scrambled mid-slot
    // R9 writes
    cpu_access(15'h1234, 1'b0, 1'b0, 8'hA5, 1'b1);
    cpu_access(15'h0081, 1'b0, 1'b0, 8'h3C, 1'b0);
    // R7 and R10 ROM accesses, including a ROM write
    cpu_access(15'h4000, 1'b1, 1'b1, 8'h00, 1'b1);
    cpu_access(15'h4001, 1'b0, 1'b1, 8'hFF, 1'b0);
    // mixed ordering
    cpu_access(15'h0100, 1'b1, 1'b0, 8'h00, 1'b0);
    cpu_access(15'h5555, 1'b1, 1'b1, 8'h00, 1'b0);
    cpu_access(15'h6F0E, 1'b0, 1'b0, 8'h5A, 1'b1);
    cpu_access(15'h3333, 1'b1, 1'b0, 8'h00, 1'b1);
    // idle ROM cycles to drain
    cpu_access(15'h0000, 1'b1, 1'b1, 8'h00, 1'b0);
    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all accesses completed", exp_q.size(), 0);
    chk(wn == 1'b0, "R9 write nibbles paired", int'(wn), 0);
    finish_run();
  end

endmodule